// File: doc/BRIEF.md
# Host-to-Processor DMA Byte Assembler

This block sits on the host side of an 8-bit host port that feeds a 24-bit processor word path. An external DMA controller delivers one byte per acknowledge strobe. The block collects those bytes into three byte slots (high, middle, low) and then moves the finished word into a receive register that the processor reads. The pacing is a request/acknowledge pair. The block raises `dma_req` while it can take a byte, and the controller answers with a one-cycle `dma_ack` that carries `dma_data`.

A two-bit byte-slot counter decides which slot each byte lands in. An init pulse or the write of the low byte reloads the counter from the word-size mode:

- 24-bit words start at the high slot.
- 16-bit words start at the middle slot.
- 8-bit words start at the low slot.

Every word therefore ends on the low slot, and that write hands the word to the processor side. Two flags track progress. `tx_empty` means the byte slots are free. `rx_full` means the receive register holds an unread word. The processor receive interrupt follows `rx_full`, gated by an enable.

Top module: `hdma_rx_assembler`

## Requirements
- R1: `mode` encodes 00 = DMA off, 01 = 24-bit words, 10 = 16-bit words, 11 = 8-bit words. `dma_req` is asserted only when `mode` is not 00 and `dir_h2p` is 1. In every other case it stays 0, and an acknowledge strobe changes nothing.
- R2: Bytes land in slots high, middle, low, in that order. The receive word is {high, middle, low}, with the high byte in bits 23:16. A 24-bit word takes three strobes starting at high. A 16-bit word takes two strobes starting at middle. An 8-bit word takes one strobe at low.
- R3: After a strobe that writes the high or middle slot, the counter advances by one slot and `dma_req` is 1 again in the next cycle.
- R4: `dma_req` is 0 in every cycle in which `dma_ack` is 1.
- R5: The clock edge that writes the low slot clears `tx_empty`, drops `dma_req` and reloads the counter from `mode`.
- R6: If `rx_full` is 0, the word moves into `rx_word` on the next clock edge after the low-slot write. That edge sets `rx_full` to 1 and `tx_empty` to 1, and `dma_req` returns.
- R7: While `rx_full` stays 1, a finished word waits in the slots. `rx_word` holds its value, `dma_req` stays 0, and strobes are ignored. The word moves on the edge after the processor read clears `rx_full`.
- R8: `rx_irq` is 1 exactly when `rx_full` and `rx_ie` are both 1. A `cpu_rd` pulse clears `rx_full`.
- R9: An `init` pulse sets `tx_empty`, clears `rx_full`, clears the three byte slots and loads the counter from `mode`. In a DMA mode with `dir_h2p` = 1, `dma_req` is 1 in the next cycle.
- R10: After reset, `tx_empty` = 1, `rx_full` = 0, `dma_req` = 0 (with `mode` = 00), `rx_irq` = 0 and `rx_word` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Word-size mode (00 off, 01 24-bit, 10 16-bit, 11 8-bit) |
| dir_h2p | input | 1 | Host-to-processor direction selected |
| init | input | 1 | Channel initialise pulse |
| rx_ie | input | 1 | Receive interrupt enable |
| dma_ack | input | 1 | One-cycle acknowledge strobe from the DMA controller |
| dma_data | input | 8 | Byte delivered with the strobe |
| cpu_rd | input | 1 | Processor read of the receive register |
| dma_req | output | 1 | Request for the next byte |
| tx_empty | output | 1 | Byte slots free |
| rx_full | output | 1 | Receive register holds an unread word |
| rx_word | output | 24 | Receive register |
| rx_irq | output | 1 | Processor receive interrupt |

## Verification
The assertions check the per-cycle rules on every cycle:

- the request is silent during a strobe and after the last byte;
- the slot counter stays in range and steps by one;
- the hand-over follows one clock after the low-byte write;
- the flags settle correctly after a move, a read and an init;
- the interrupt tracks `rx_full`.

Other properties only the bench's scenarios can show. These are the byte order inside the received word for each word size, and the clearing of stale slots by init. They also include the ordering of two words when the processor is slow, and the fact that strobes during back-pressure or in the off mode do not corrupt data. The scoreboard compares each received word against the word the driver sent.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_W24 = 2'b01,
    MODE_W16 = 2'b10,
    MODE_W8  = 2'b11
  } xfer_mode_e;

  localparam int NSLOT = 3;
  typedef logic [1:0] slot_t;
  localparam slot_t SLOT_HIGH = 2'd0;
  localparam slot_t SLOT_LAST = slot_t'(NSLOT - 1);

  // first slot of a word for a given word-size mode
  function automatic slot_t first_slot(input logic [1:0] m);
    case (m)
      MODE_W24: first_slot = SLOT_HIGH;
      MODE_W16: first_slot = 2'd1;
      default:  first_slot = SLOT_LAST;
    endcase
  endfunction

  function automatic logic dma_on(input logic [1:0] m);
    dma_on = (m != MODE_OFF);
  endfunction

  function automatic slot_t next_slot(input slot_t s);
    next_slot = slot_t'(s + 2'd1);
  endfunction

endpackage

// File: rtl/hdma_slot_ctr.sv
module hdma_slot_ctr
  import hdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] mode,
  output slot_t      slot,
  output logic       slot_is_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slot <= SLOT_LAST;
    else if (load)  slot <= first_slot(mode);
    else if (step)  slot <= next_slot(slot);
  end

  assign slot_is_last = (slot == SLOT_LAST);

  // R3: counter never leaves the three byte slots
  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_LAST);

  // R3: a non-final byte advances the counter by exactly one slot
  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> slot == slot_t'($past(slot) + 2'd1));

  // R5: a reload picks the mode's first slot
  p_slot_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> slot == first_slot($past(mode)));

endmodule

// File: rtl/hdma_byte_bank.sv
module hdma_byte_bank
  import hdma_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = NSLOT * BYTE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  slot_t             slot,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] word
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= '0;
      else if (clr)                         q <= '0;
      else if (wr && slot == slot_t'(g))    q <= din;
    end
    // slot 0 (high) occupies the top byte of the word
    assign word[(NSLOT-1-g)*BYTE_W +: BYTE_W] = q;
  end

endmodule

// File: rtl/hdma_word_path.sv
module hdma_word_path
  import hdma_pkg::*;
#(
  parameter int WORD_W = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              last_wr,
  input  logic              rd,
  input  logic [WORD_W-1:0] in_word,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              move,
  output logic [WORD_W-1:0] rx_word
);

  assign move = !tx_empty && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      rx_word  <= '0;
    end else if (init) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
    end else begin
      if (move) begin
        tx_empty <= 1'b1;
        rx_full  <= 1'b1;
        rx_word  <= in_word;
      end else begin
        if (last_wr) tx_empty <= 1'b0;
        if (rd)      rx_full  <= 1'b0;
      end
    end
  end

  // R6: a move fills the receive side and frees the byte slots
  p_move_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (move && !init) |=> (rx_full && tx_empty));

  // R7: an unread word stays put until the processor reads it
  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd && !init) |=> (rx_full && $stable(rx_word)));

  // R8: a processor read empties the receive register
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rd && !init) |=> !rx_full);

  // R9: init leaves the channel empty on both sides
  p_init_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (tx_empty && !rx_full));

endmodule

// File: rtl/hdma_rx_assembler.sv
module hdma_rx_assembler
  import hdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        dir_h2p,
  input  logic        init,
  input  logic        rx_ie,
  input  logic        dma_ack,
  input  logic [7:0]  dma_data,
  input  logic        cpu_rd,
  output logic        dma_req,
  output logic        tx_empty,
  output logic        rx_full,
  output logic [23:0] rx_word,
  output logic        rx_irq
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = NSLOT * BYTE_W;

  // named internal events
  logic        chan_on;
  logic        byte_wr;
  logic        last_wr;
  logic        slot_step;
  logic        slot_load;
  logic        word_move;
  logic        slot_is_last;
  slot_t       slot;
  logic [WORD_W-1:0] bank_word;

  assign chan_on   = dma_on(mode) && dir_h2p;
  assign byte_wr   = dma_ack && chan_on && tx_empty && !init;
  assign last_wr   = byte_wr && slot_is_last;
  assign slot_step = byte_wr && !slot_is_last;
  assign slot_load = init || last_wr;
  assign dma_req   = chan_on && tx_empty && !dma_ack;
  assign rx_irq    = rx_full && rx_ie;

  hdma_slot_ctr u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (slot_load),
    .step         (slot_step),
    .mode         (mode),
    .slot         (slot),
    .slot_is_last (slot_is_last)
  );

  hdma_byte_bank #(.BYTE_W(BYTE_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (init),
    .wr    (byte_wr),
    .slot  (slot),
    .din   (dma_data),
    .word  (bank_word)
  );

  hdma_word_path #(.WORD_W(WORD_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (init),
    .last_wr  (last_wr),
    .rd       (cpu_rd),
    .in_word  (bank_word),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .move     (word_move),
    .rx_word  (rx_word)
  );

  // R1: no request in the off mode
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF || !dir_h2p) |-> !dma_req);

  // R4: request is down while the strobe is up
  p_ack_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |-> !dma_req);

  // R5: the low-slot write silences the request
  p_last_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> !dma_req);

  // R6: hand-over one clock after the low-slot write when receive side is free
  p_move_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_wr && !rx_full) |=> word_move);

  // R8: interrupt follows a pending word when enabled
  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_ie) |-> rx_irq);

  // R9: request returns right after init in an active channel
  p_init_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init && chan_on && !dma_ack) |=> (dma_req || dma_ack || !chan_on));

endmodule

// File: tb/hdma_rx_assembler_test.sv
module hdma_rx_assembler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        dir_h2p = 1'b0;
  logic        init = 1'b0;
  logic        rx_ie = 1'b1;
  logic        dma_ack = 1'b0;
  logic [7:0]  dma_data = 8'h00;
  logic        cpu_rd = 1'b0;
  logic        dma_req, tx_empty, rx_full, rx_irq;
  logic [23:0] rx_word;

  int checks = 0;
  int errors = 0;
  bit hold_rd = 1'b1;
  bit done = 1'b0;
  logic [23:0] expq[$];

  always #2 clk = ~clk;

  hdma_rx_assembler uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir_h2p(dir_h2p), .init(init),
    .rx_ie(rx_ie), .dma_ack(dma_ack), .dma_data(dma_data), .cpu_rd(cpu_rd),
    .dma_req(dma_req), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_word(rx_word), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected word from the requirements: unsent slots were cleared by init
  function automatic logic [23:0] expect_word(input logic [1:0] m, input logic [23:0] w);
    logic [7:0] hi, mid;
    hi  = (m == 2'b01) ? w[23:16] : 8'h00;
    mid = (m == 2'b11) ? 8'h00 : w[15:8];
    return {hi, mid, w[7:0]};
  endfunction

  // one strobe; we are just after a negedge
  task automatic put_byte(input logic [7:0] d, input bit last);
    while (!dma_req) @(negedge clk);
    dma_data = d;
    dma_ack  = 1'b1;
    #1;
    chk(dma_req == 1'b0, "R4", "req during ack", 32'(dma_req), 0);
    @(negedge clk);
    dma_ack = 1'b0;
    #1;
    if (!last)
      chk(dma_req == 1'b1, "R3", "req back after middle byte", 32'(dma_req), 1);
    else
      chk(!tx_empty && !dma_req, "R5", "tx_empty,req after low byte",
          32'({tx_empty, dma_req}), 0);
  endtask

  // driver: pushes the expected word, then feeds its bytes
  task automatic send_word(input logic [1:0] m, input logic [23:0] w, input bit free_rx);
    int n;
    n = (m == 2'b01) ? 3 : (m == 2'b10) ? 2 : 1;
    expq.push_back(expect_word(m, w));
    for (int i = n - 1; i >= 0; i--) put_byte(w[i*8 +: 8], i == 0);
    if (free_rx) begin
      @(negedge clk);
      #1;
      chk(rx_full && tx_empty, "R6", "one-clock hand-over", 32'({rx_full, tx_empty}), 3);
    end
  endtask

  task automatic do_init(input logic [1:0] m, input logic d);
    @(negedge clk);
    mode = m; dir_h2p = d; init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    #1;
  endtask

  task automatic drain();
    hold_rd = 1'b0;
    while (expq.size() != 0 || rx_full) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
  endtask

  // monitor: pops and compares every received word, then reads it
  always @(negedge clk) begin
    if (cpu_rd) begin
      cpu_rd <= 1'b0;
      chk(rx_full == 1'b0, "R8", "read clears rx_full", 32'(rx_full), 0);
    end else if (rst_n && rx_full && !hold_rd) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected word", 32'(rx_word), 0);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk(rx_word == e, "R2", "received word", 32'(rx_word), 32'(e));
      end
      chk(rx_irq == rx_ie, "R8", "irq vs enable", 32'(rx_irq), 32'(rx_ie));
      cpu_rd <= 1'b1;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(tx_empty && !rx_full && !dma_req && !rx_irq && rx_word == 0, "R10",
        "reset state", 32'({tx_empty, rx_full, dma_req, rx_irq}), 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    hold_rd = 1'b0;

    // 24-bit words
    do_init(2'b01, 1'b1);
    chk(dma_req == 1'b1, "R9", "req after init", 32'(dma_req), 1);
    send_word(2'b01, 24'h123456, 1);
    send_word(2'b01, 24'hA5C3F0, 1);
    drain();

    // 16-bit and 8-bit words
    do_init(2'b10, 1'b1);
    send_word(2'b10, 24'h00BEEF, 1);
    send_word(2'b10, 24'h007E81, 1);
    drain();
    do_init(2'b11, 1'b1);
    send_word(2'b11, 24'h00005A, 1);
    send_word(2'b11, 24'h0000C3, 1);
    send_word(2'b11, 24'h0000FF, 1);
    drain();

    // R1: direction off and mode off keep the request low, strobes ignored
    do_init(2'b01, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    chk(dma_req == 1'b0, "R1", "req with direction off", 32'(dma_req), 0);
    do_init(2'b00, 1'b1);
    dma_data = 8'h77; dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!dma_req && tx_empty && !rx_full, "R1", "off mode ignores strobe",
        32'({dma_req, tx_empty, rx_full}), 32'h2);

    // R7: back-pressure with a slow processor
    do_init(2'b01, 1'b1);
    hold_rd = 1'b1;
    send_word(2'b01, 24'h111111, 1);
    send_word(2'b01, 24'h222222, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_empty && rx_full && !dma_req, "R7", "word waits, req low",
        32'({tx_empty, rx_full, dma_req}), 32'h2);
    chk(rx_word == 24'h111111, "R7", "rx_word held", 32'(rx_word), 32'h111111);
    dma_data = 8'hEE; dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    drain();

    // R8: interrupt disabled
    rx_ie = 1'b0;
    send_word(2'b01, 24'h0F1E2D, 1);
    drain();
    rx_ie = 1'b1;

    // R9: init clears a pending word
    hold_rd = 1'b1;
    send_word(2'b01, 24'h333333, 1);
    void'(expq.pop_back());
    do_init(2'b01, 1'b1);
    chk(!rx_full && tx_empty && !rx_irq, "R9", "init clears pending word",
        32'({rx_full, tx_empty, rx_irq}), 32'h2);
    hold_rd = 1'b0;

    // R9: init mid-word clears slots and restarts the counter
    put_byte(8'hAA, 0);
    put_byte(8'hBB, 0);
    do_init(2'b10, 1'b1);
    send_word(2'b10, 24'h00CCDD, 1);
    drain();
    chk(expq.size() == 0, "R2", "scoreboard empty", 32'(expq.size()), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule